// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block forms the effective memory address and the updated base value for a load or store. The offset comes either from a register or from a small unsigned constant, and it is scaled by the access size. The scaled offset is then added to or subtracted from the base. In linear mode the plain 32-bit result is used. In circular mode only the low N+1 bits of the result are taken, and every bit above them keeps the base's value. This confines the address to a window of 2^(N+1) bytes, however large the offset is.

A 32-bit configuration word holds two things. It holds a 2-bit mode field for each of eight circular-capable base registers. It also holds two shared 5-bit block-size fields, and the mode field of the active register picks one of them. The memory address is produced combinationally in the same cycle. The write-back of the updated base is registered and appears after the next clock edge.

Top module: `circ_addr_gen`

## Requirements
- R1: The offset is shifted left by the size code: code 00 (byte) by 0, 01 (halfword) by 1, 10 (word) by 2, 11 (doubleword) by 3.
- R2: In linear mode the full 32-bit result base+scaled or base-scaled is used, wrapping modulo 2^32. Linear mode means a mode field of 00 or 11.
- R3: In circular mode, result bits N..0 come from the sum or difference, and bits 31..N+1 equal the base.
- R4: Subtraction in circular mode wraps inside the same window. Stepping below the window's low edge yields an address near its top.
- R5: The mode of base index i (0..7) is cfg[2i+1:2i]: 01 selects the block size in cfg[20:16], 10 selects the block size in cfg[25:21]. Indices 8..15 are always linear.
- R6: The block size N is a byte measure and is not scaled by the access size; the window is 2^(N+1) bytes. N=31 leaves all 32 bits free.
- R7: With pre-modify (pre_mod=1), mem_addr equals the result. With post-modify, mem_addr equals base_val unchanged.
- R8: When wb_en is 1, wb_valid is 1 after the next rising edge, with wb_idx equal to base_idx and wb_value equal to the result. When wb_en is 0, wb_valid is 0 after the next edge.
- R9: During reset (rst_n low) wb_valid, wb_idx and wb_value are all 0.
- R10: With use_imm=1 the 5-bit imm_off, zero-extended, is the offset; otherwise reg_off is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_val | input | 32 | Current base register value |
| base_idx | input | 4 | Base register index |
| reg_off | input | 32 | Register offset |
| imm_off | input | 5 | Unsigned constant offset |
| use_imm | input | 1 | 1 selects imm_off as the offset |
| size_code | input | 2 | Access size code |
| do_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| pre_mod | input | 1 | 1 pre-modify, 0 post-modify |
| wb_en | input | 1 | Write the updated base back |
| mode_cfg | input | 32 | Mode and block-size configuration |
| mem_addr | output | 32 | Effective memory address |
| wb_valid | output | 1 | Registered write-back strobe |
| wb_idx | output | 4 | Registered write-back index |
| wb_value | output | 32 | Registered updated base value |

## Verification
mem_addr is combinational, so it is checked in the same cycle as the stimulus: the inputs are driven on a falling edge and mem_addr is sampled shortly afterwards. The write-back triple is due exactly one rising edge later. The driver pushes the expected triple into a queue, and a monitor pops one item just after each rising edge and compares it there. Each stimulus is therefore checked against the edge that registers it and never against a neighbouring one.

// File: rtl/circ_addr_pkg.sv
package circ_addr_pkg;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 4;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        MODE_LIN = 2'b00,
        MODE_BKA = 2'b01,
        MODE_BKB = 2'b10,
        MODE_RSV = 2'b11
    } mode_e;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] value;
    } wb_state_t;
endpackage

// File: rtl/circ_off_scale.sv
module circ_off_scale
    import circ_addr_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int IMM_W = 5
) (
    input  logic [AW-1:0]    reg_off,
    input  logic [IMM_W-1:0] imm_off,
    input  logic             use_imm,
    input  logic [1:0]       size_code,
    output logic [AW-1:0]    scaled
);
    logic [AW-1:0] raw_d;

    always_comb begin
        raw_d = use_imm ? {{(AW-IMM_W){1'b0}}, imm_off} : reg_off;
        unique case (size_e'(size_code))
            SZ_BYTE:  scaled = raw_d;
            SZ_HALF:  scaled = raw_d << 1;
            SZ_WORD:  scaled = raw_d << 2;
            default:  scaled = raw_d << 3;
        endcase
    end
endmodule

// File: rtl/circ_mode_sel.sv
module circ_mode_sel
    import circ_addr_pkg::*;
#(
    parameter int CW       = 32,
    parameter int IW       = IDX_W,
    parameter int NUM_CIRC = 8,
    parameter int BK_W     = 5,
    parameter int BKA_LSB  = 16,
    parameter int BKB_LSB  = 21
) (
    input  logic [CW-1:0]   cfg,
    input  logic [IW-1:0]   idx,
    output logic            circ,
    output logic [BK_W-1:0] nsel
);
    localparam int SEL_W = $clog2(NUM_CIRC);

    logic [1:0] fld [NUM_CIRC];

    for (genvar g = 0; g < NUM_CIRC; g++) begin : g_fld
        assign fld[g] = cfg[2*g +: 2];
    end

    mode_e mode_d;

    always_comb begin
        mode_d = MODE_LIN;
        if (int'(idx) < NUM_CIRC) begin
            mode_d = mode_e'(fld[idx[SEL_W-1:0]]);
        end
        unique case (mode_d)
            MODE_BKA: begin circ = 1'b1; nsel = cfg[BKA_LSB +: BK_W]; end
            MODE_BKB: begin circ = 1'b1; nsel = cfg[BKB_LSB +: BK_W]; end
            default:  begin circ = 1'b0; nsel = '0; end
        endcase
    end
endmodule

// File: rtl/circ_wrap_add.sv
module circ_wrap_add
    import circ_addr_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int BK_W = 5
) (
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   scaled,
    input  logic            do_sub,
    input  logic            circ,
    input  logic [BK_W-1:0] nsel,
    output logic [AW-1:0]   keep_mask,
    output logic [AW-1:0]   result
);
    logic [AW-1:0] sum_d;
    logic [AW:0]   span_d;

    always_comb begin
        sum_d  = do_sub ? (base - scaled) : (base + scaled);
        span_d = ({{AW{1'b0}}, 1'b1} << ({1'b0, nsel} + 6'd1)) - {{AW{1'b0}}, 1'b1};
        keep_mask = circ ? span_d[AW-1:0] : {AW{1'b1}};
        result = (base & ~keep_mask) | (sum_d & keep_mask);
    end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import circ_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] reg_off,
    input  logic [4:0]        imm_off,
    input  logic              use_imm,
    input  logic [1:0]        size_code,
    input  logic              do_sub,
    input  logic              pre_mod,
    input  logic              wb_en,
    input  logic [31:0]       mode_cfg,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [ADDR_W-1:0] wb_value
);
    localparam int BK_W = 5;

    logic [ADDR_W-1:0] scaled;
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] upd;
    logic              circ;
    logic [BK_W-1:0]   nsel;
    wb_state_t         wb_d, wb_q;

    circ_off_scale #(.AW(ADDR_W), .IMM_W(5)) u_scale (
        .reg_off  (reg_off),
        .imm_off  (imm_off),
        .use_imm  (use_imm),
        .size_code(size_code),
        .scaled   (scaled)
    );

    circ_mode_sel #(.CW(32), .IW(IDX_W), .NUM_CIRC(8), .BK_W(BK_W),
                    .BKA_LSB(16), .BKB_LSB(21)) u_mode (
        .cfg (mode_cfg),
        .idx (base_idx),
        .circ(circ),
        .nsel(nsel)
    );

    circ_wrap_add #(.AW(ADDR_W), .BK_W(BK_W)) u_wrap (
        .base     (base_val),
        .scaled   (scaled),
        .do_sub   (do_sub),
        .circ     (circ),
        .nsel     (nsel),
        .keep_mask(keep_mask),
        .result   (upd)
    );

    assign mem_addr = pre_mod ? upd : base_val;

    always_comb begin
        wb_d       = wb_q;
        wb_d.valid = wb_en;
        if (wb_en) begin
            wb_d.idx   = base_idx;
            wb_d.value = upd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wb_valid = wb_q.valid;
    assign wb_idx   = wb_q.idx;
    assign wb_value = wb_q.value;

    p_upper_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        circ |-> (((upd ^ base_val) & ~keep_mask) == '0));

    p_post_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_mod |-> (mem_addr == base_val));

    p_pre_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_mod |-> (mem_addr == upd));

    p_wb_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (wb_valid && wb_value == $past(upd) && wb_idx == $past(base_idx)));

    p_wb_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |=> !wb_valid);

    p_high_idx_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        base_idx[3] |-> !circ);
endmodule

// File: tb/circ_addr_gen_tb.sv
module circ_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_val = '0;
    logic [3:0]  base_idx = '0;
    logic [31:0] reg_off = '0;
    logic [4:0]  imm_off = '0;
    logic        use_imm = 1'b0;
    logic [1:0]  size_code = '0;
    logic        do_sub = 1'b0;
    logic        pre_mod = 1'b0;
    logic        wb_en = 1'b0;
    logic [31:0] mode_cfg = '0;
    logic [31:0] mem_addr;
    logic        wb_valid;
    logic [3:0]  wb_idx;
    logic [31:0] wb_value;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string       rq;
        logic        valid;
        logic [3:0]  idx;
        logic [31:0] value;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    circ_addr_gen u_dut (.*);

    function automatic logic [31:0] model(input logic [31:0] b, input logic [31:0] off,
                                          input logic [1:0] sz, input logic sub,
                                          input logic [31:0] cfg, input logic [3:0] ix);
        logic [31:0] sc, s;
        logic [1:0]  m;
        logic [4:0]  n;
        logic [63:0] win, b64, s64;
        sc = off << sz;
        s  = sub ? b - sc : b + sc;
        m  = (ix < 8) ? cfg[2*ix +: 2] : 2'b00;
        if (m == 2'b01)      n = cfg[20:16];
        else if (m == 2'b10) n = cfg[25:21];
        else return s;
        win = 64'd1 << (n + 1);
        b64 = {32'b0, b};
        s64 = {32'b0, s};
        b64 = b64 - (b64 % win) + (s64 % win);
        return b64[31:0];
    endfunction

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic apply(string rq, logic [31:0] b, logic [3:0] ix, logic imm,
                         logic [31:0] roff, logic [4:0] ioff, logic [1:0] sz,
                         logic sub, logic pre, logic wb, logic [31:0] cfg,
                         logic [31:0] exp_addr);
        logic [31:0] r;
        exp_t e;
        @(negedge clk);
        base_val = b; base_idx = ix; use_imm = imm; reg_off = roff; imm_off = ioff;
        size_code = sz; do_sub = sub; pre_mod = pre; wb_en = wb; mode_cfg = cfg;
        r = model(b, imm ? {27'b0, ioff} : roff, sz, sub, cfg, ix);
        #1;
        check({rq, " addr"}, mem_addr, exp_addr);
        check({rq, " addr-model"}, mem_addr, pre ? r : b);
        e.rq = rq; e.valid = wb; e.idx = ix; e.value = r;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.rq, " R8 wb_valid"}, {31'b0, wb_valid}, {31'b0, e.valid});
            if (e.valid) begin
                check({e.rq, " R8 wb_idx"}, {28'b0, wb_idx}, {28'b0, e.idx});
                check({e.rq, " R8 wb_value"}, wb_value, e.value);
            end
        end
    end

    initial begin
        #40000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 wb_valid", {31'b0, wb_valid}, 32'd0);
        check("R9 wb_idx", {28'b0, wb_idx}, 32'd0);
        check("R9 wb_value", wb_value, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R3 R6 R10: word step of 9 wraps 124h into window 100h..11Fh
        apply("R3", 32'h100, 4'd0, 1, 0, 5'd9, 2'b10, 0, 1, 1, 32'h0004_0001, 32'h104);
        // R7 post-modify emits the base
        apply("R7", 32'h100, 4'd0, 1, 0, 5'd9, 2'b10, 0, 0, 1, 32'h0004_0001, 32'h100);
        // R2 linear, same step
        apply("R2", 32'h100, 4'd0, 1, 0, 5'd9, 2'b10, 0, 1, 1, 32'h0, 32'h124);
        // R4 subtract below low edge: 104h-0Ch -> 118h
        apply("R4", 32'h104, 4'd0, 1, 0, 5'd3, 2'b10, 1, 1, 1, 32'h0004_0001, 32'h118);
        // R1 byte, halfword, doubleword scaling (linear)
        apply("R1", 32'h1000, 4'd2, 0, 32'h11, 5'd0, 2'b00, 0, 1, 1, 32'h0, 32'h1011);
        apply("R1", 32'h1000, 4'd2, 0, 32'h11, 5'd0, 2'b01, 0, 1, 1, 32'h0, 32'h1022);
        apply("R1", 32'h1000, 4'd2, 0, 32'h11, 5'd0, 2'b11, 1, 1, 1, 32'h0, 32'h0F78);
        // R10 register offset, large, circular: result still inside 32-byte window
        apply("R10", 32'h5000_0010, 4'd0, 0, 32'h1000_0003, 5'd0, 2'b10, 0, 1, 1,
              32'h0004_0001, 32'h5000_001C);
        // R5 BK1 on index 3 (cfg[7:6]=10, N=2): 2000_0006 + 6 -> 2000_0004
        apply("R5", 32'h2000_0006, 4'd3, 1, 0, 5'd3, 2'b01, 0, 1, 1, 32'h0040_0080, 32'h2000_0004);
        // R5 index 9 stays linear although all fields say circular
        apply("R5", 32'h2000_0006, 4'd9, 1, 0, 5'd3, 2'b01, 0, 1, 1, 32'h0045_5555, 32'h2000_000C);
        // R2 reserved mode 11 is linear
        apply("R2", 32'h2000_0006, 4'd1, 1, 0, 5'd3, 2'b01, 0, 1, 1, 32'h0004_000C, 32'h2000_000C);
        // R2 linear modulo 2^32
        apply("R2", 32'hFFFF_FFF0, 4'd0, 1, 0, 5'd8, 2'b10, 0, 1, 1, 32'h0, 32'h0000_0010);
        // R6 N=31: full width, no wrap
        apply("R6", 32'hFFFF_FFF0, 4'd0, 1, 0, 5'd8, 2'b10, 0, 1, 1, 32'h001F_0001, 32'h0000_0010);
        // R6 byte access with N=0: 2-byte window
        apply("R6", 32'h0000_0301, 4'd0, 1, 0, 5'd1, 2'b00, 0, 1, 1, 32'h0000_0001, 32'h0000_0300);
        // R8 no write-back
        apply("R8", 32'h40, 4'd5, 1, 0, 5'd1, 2'b00, 0, 0, 0, 32'h0, 32'h40);
        apply("R8", 32'h44, 4'd6, 1, 0, 5'd2, 2'b00, 0, 1, 1, 32'h0, 32'h46);
        @(negedge clk);
        wb_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule